// File: doc/BRIEF.md
# Hidden Read-Sequence Command Detector

This block watches the accesses made to a byte-wide memory port. It finds a command hidden inside ordinary read traffic. The command is a key of six reads that must arrive in a fixed order. The first five addresses of the key are always the same. The sixth address chooses the command: either a request to save the working memory into its nonvolatile copy, or a request to restore the working memory from that copy.

The strobe input pulses once per access. It has already been synchronized to the system clock. The block does not carry out any transfer. It reports progress on `step_o`, and when a command is recognized it raises a single-cycle request pulse.

While the transfer controller reports busy, the block ignores all accesses and stays idle.

Top module: `seq_cmd_detect`

## Requirements
- R1: While `rst_n` is low at a clock edge, the detector returns to idle: `step_o`=0, and `store_o` and `recall_o` are 0 after that edge.
- R2: `step_o` counts the key entries matched so far. The prefix is 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F, in that order. Each matching read (`acc_i`=1, `wr_i`=0) raises `step_o` by one, up to 5, after the edge that samples the read.
- R3: A read of 0x0FC0 while `step_o`=5 makes `store_o` high for exactly the next cycle and returns `step_o` to 0.
- R4: A read of 0x0C63 while `step_o`=5 makes `recall_o` high for exactly the next cycle and returns `step_o` to 0.
- R5: Address bit 14 plays no part in matching. Only bits 13:0 are compared.
- R6: An access with `wr_i`=1 aborts the sequence, `step_o` goes to 0, even when its address is the next key entry.
- R7: A read of any address other than the next expected entry aborts the sequence. This includes a second read of the address just matched.
- R8: A read of the reserved code 0x339C while `step_o`=5 produces no pulse and aborts the sequence.
- R9: When the read that aborts a sequence is itself to 0x0E38, `step_o` becomes 1 instead of 0.
- R10: While `busy_i` is 1, `step_o` goes to 0 at every edge, no pulse is produced, and accesses are ignored.
- R11: Cycles with `acc_i`=0 leave `step_o` unchanged.
- R12: `store_o` and `recall_o` are never high together, and neither is high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| busy_i | input | 1 | Transfer in progress; ignore accesses |
| acc_i | input | 1 | One-cycle strobe per memory access |
| wr_i | input | 1 | The access is a write |
| addr_i | input | 15 | Access address |
| store_o | output | 1 | Save request pulse |
| recall_o | output | 1 | Restore request pulse |
| step_o | output | 3 | Number of key entries matched so far (0 to 5) |

## Verification
The hardest case to reach from the ports is an abort that happens at the same time as a restart. This is a stray read of 0x0E38 that arrives deep in the sequence, or on the final step. The correct result is step 1, not idle, and then a complete command can follow from there.

The stimulus builds partial keys of several lengths and breaks them at chosen points with:
- writes,
- repeated reads,
- the reserved code,
- 0x0E38.

It also places busy cycles and idle gaps mid-sequence. Each access carries its expected step and pulse values into the scoreboard.

// File: rtl/seq_cmd_pkg.sv
package seq_cmd_pkg;
    localparam int CMD_W      = 14;
    localparam int PREFIX_LEN = 5;
    localparam int STEP_W     = $clog2(PREFIX_LEN + 1);

    localparam logic [CMD_W-1:0] CODE_SAVE    = 14'h0FC0;
    localparam logic [CMD_W-1:0] CODE_RESTORE = 14'h0C63;
    localparam logic [CMD_W-1:0] CODE_TEST    = 14'h339C;

    function automatic logic [CMD_W-1:0] key_word(input int idx);
        case (idx)
            0:       key_word = 14'h0E38;
            1:       key_word = 14'h31C7;
            2:       key_word = 14'h03E0;
            3:       key_word = 14'h3C1F;
            default: key_word = 14'h303F;
        endcase
    endfunction

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic              save;
        logic              restore;
    } det_state_t;
endpackage

// File: rtl/seq_key_match.sv
module seq_key_match
    import seq_cmd_pkg::*;
#(
    parameter int KEY_LEN = PREFIX_LEN,
    parameter int SW      = STEP_W
) (
    input  logic [CMD_W-1:0] addr_cmp,
    input  logic [SW-1:0]    step,
    output logic             hit_next,
    output logic             hit_first,
    output logic             hit_save,
    output logic             hit_restore
);
    localparam int EXT_N = 1 << SW;

    logic [KEY_LEN-1:0] eq;
    logic [EXT_N-1:0]   eq_ext;
    logic               at_last;

    genvar g;
    generate
        for (g = 0; g < KEY_LEN; g++) begin : g_cmp
            assign eq[g] = (addr_cmp == key_word(g));
        end
    endgenerate

    always_comb begin
        eq_ext              = '0;
        eq_ext[KEY_LEN-1:0] = eq;
    end

    assign at_last     = (step == SW'(KEY_LEN));
    assign hit_next    = eq_ext[step];
    assign hit_first   = eq[0];
    assign hit_save    = at_last && (addr_cmp == CODE_SAVE);
    assign hit_restore = at_last && (addr_cmp == CODE_RESTORE);
endmodule

// File: rtl/seq_cmd_ctrl.sv
module seq_cmd_ctrl
    import seq_cmd_pkg::*;
#(
    parameter int KEY_LEN = PREFIX_LEN,
    parameter int SW      = STEP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy_i,
    input  logic          acc_i,
    input  logic          wr_i,
    input  logic          is_test_code,
    input  logic          hit_next,
    input  logic          hit_first,
    input  logic          hit_save,
    input  logic          hit_restore,
    output logic [SW-1:0] step_q_o,
    output logic          save_o,
    output logic          restore_o
);
    typedef struct packed {
        logic [SW-1:0] step;
        logic          save;
        logic          restore;
    } ctl_t;

    ctl_t st_d, st_q;
    logic rd_live;

    assign rd_live = acc_i && !wr_i && !busy_i;

    always_comb begin
        st_d         = st_q;
        st_d.save    = 1'b0;
        st_d.restore = 1'b0;
        if (busy_i) begin
            st_d.step = '0;
        end else if (acc_i) begin
            if (wr_i) begin
                st_d.step = '0;
            end else if (hit_save) begin
                st_d.step = '0;
                st_d.save = 1'b1;
            end else if (hit_restore) begin
                st_d.step    = '0;
                st_d.restore = 1'b1;
            end else if (hit_next) begin
                st_d.step = st_q.step + SW'(1);
            end else if (hit_first) begin
                st_d.step = SW'(1);
            end else begin
                st_d.step = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign step_q_o  = st_q.step;
    assign save_o    = st_q.save;
    assign restore_o = st_q.restore;

    assert_step_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.step <= SW'(KEY_LEN));
    assert_step_climb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.step > SW'(1)) |-> ($past(st_q.step) == st_q.step - SW'(1) || $past(st_q.step) == st_q.step));
    assert_save_from_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.save |-> ($past(st_q.step) == SW'(KEY_LEN) && st_q.step == '0));
    assert_restore_from_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.restore |-> ($past(st_q.step) == SW'(KEY_LEN) && st_q.step == '0));
    assert_write_aborts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && wr_i) |=> (st_q.step == '0 && !st_q.save && !st_q.restore));
    assert_test_code_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_live && is_test_code) |=> (!st_q.save && !st_q.restore));
    assert_busy_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> (st_q.step == '0 && !st_q.save && !st_q.restore));
    assert_no_strobe_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_i && !busy_i) |=> $stable(st_q.step));
    assert_pulse_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_q.save, st_q.restore}));
    assert_pulse_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.save || st_q.restore) |=> (!st_q.save && !st_q.restore));
endmodule

// File: rtl/seq_cmd_detect.sv
module seq_cmd_detect
    import seq_cmd_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic              acc_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              store_o,
    output logic              recall_o,
    output logic [STEP_W-1:0] step_o
);
    logic [CMD_W-1:0]  addr_cmp;
    logic [STEP_W-1:0] step_q;
    logic hit_next, hit_first, hit_save, hit_restore;

    assign addr_cmp = addr_i[CMD_W-1:0];

    seq_key_match #(.KEY_LEN(PREFIX_LEN), .SW(STEP_W)) u_match (
        .addr_cmp   (addr_cmp),
        .step       (step_q),
        .hit_next   (hit_next),
        .hit_first  (hit_first),
        .hit_save   (hit_save),
        .hit_restore(hit_restore)
    );

    seq_cmd_ctrl #(.KEY_LEN(PREFIX_LEN), .SW(STEP_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .busy_i      (busy_i),
        .acc_i       (acc_i),
        .wr_i        (wr_i),
        .is_test_code(addr_cmp == CODE_TEST),
        .hit_next    (hit_next),
        .hit_first   (hit_first),
        .hit_save    (hit_save),
        .hit_restore (hit_restore),
        .step_q_o    (step_q),
        .save_o      (store_o),
        .restore_o   (recall_o)
    );

    assign step_o = step_q;

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (step_o == '0 && !store_o && !recall_o));
endmodule

// File: tb/seq_cmd_detect_tb.sv
module seq_cmd_detect_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        busy_i = 1'b0, acc_i = 1'b0, wr_i = 1'b0;
    logic [14:0] addr_i = '0;
    logic        store_o, recall_o;
    logic [2:0]  step_o;

    int total = 0, bad = 0;
    bit done = 0;

    int    q_step[$];
    bit    q_st[$];
    bit    q_rc[$];
    string q_tag[$];

    always #2 clk = ~clk;

    seq_cmd_detect u_dut (
        .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .acc_i(acc_i), .wr_i(wr_i),
        .addr_i(addr_i), .store_o(store_o), .recall_o(recall_o), .step_o(step_o)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp_v);
        end
    endtask

    // driver: one access (or idle) per cycle, expected results queued
    task automatic cyc(input bit a, input bit w, input logic [14:0] ad, input bit b,
                       input int es, input bit est, input bit erc, input string tag);
        @(negedge clk);
        acc_i = a; wr_i = w; addr_i = ad; busy_i = b;
        q_step.push_back(es); q_st.push_back(est); q_rc.push_back(erc); q_tag.push_back(tag);
    endtask

    task automatic rd(input logic [14:0] ad, input int es, input string tag);
        cyc(1, 0, ad, 0, es, 0, 0, tag);
    endtask

    task automatic prefix(input int n, input logic [14:0] hi, input string tag);
        logic [14:0] k [5] = '{15'h0E38, 15'h31C7, 15'h03E0, 15'h3C1F, 15'h303F};
        for (int i = 0; i < n; i++) rd(k[i] | hi, i + 1, tag);
    endtask

    task automatic idle(input int es, input string tag);
        cyc(0, 0, 15'h0, 0, es, 0, 0, tag);
    endtask

    // monitor: compare after each edge
    always @(posedge clk) begin
        #1;
        if (q_step.size() > 0) begin
            int es; bit est, erc; string t;
            es = q_step.pop_front(); est = q_st.pop_front(); erc = q_rc.pop_front(); t = q_tag.pop_front();
            chk(step_o == 3'(es), t, "step_o", int'(step_o), es);
            chk(store_o == est, t, "store_o", int'(store_o), int'(est));
            chk(recall_o == erc, t, "recall_o", int'(recall_o), int'(erc));
        end
    end

    initial begin
        #100000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(step_o == 0 && !store_o && !recall_o, "R1", "reset idle", int'(step_o), 0);
        rst_n = 1'b1;

        idle(0, "R11"); idle(0, "R11");
        prefix(5, 15'h0, "R2");
        cyc(1, 0, 15'h0FC0, 0, 0, 1, 0, "R3");
        idle(0, "R12");

        prefix(5, 15'h4000, "R5");
        cyc(1, 0, 15'h4C63, 0, 0, 0, 1, "R4");
        idle(0, "R12");

        prefix(3, 15'h0, "R6");
        cyc(1, 1, 15'h3C1F, 0, 0, 0, 0, "R6");
        rd(15'h3C1F, 0, "R6");

        prefix(2, 15'h0, "R7");
        rd(15'h31C7, 0, "R7");
        prefix(4, 15'h0, "R7");
        rd(15'h1234, 0, "R7");

        prefix(5, 15'h0, "R8");
        rd(15'h339C, 0, "R8");
        idle(0, "R8");

        prefix(3, 15'h0, "R9");
        rd(15'h0E38, 1, "R9");
        rd(15'h31C7, 2, "R9"); rd(15'h03E0, 3, "R9"); rd(15'h3C1F, 4, "R9"); rd(15'h303F, 5, "R9");
        rd(15'h0E38, 1, "R9");
        cyc(1, 1, 15'h0E38, 0, 0, 0, 0, "R9");

        prefix(2, 15'h0, "R10");
        cyc(0, 0, 15'h0, 1, 0, 0, 0, "R10");
        rd(15'h03E0, 0, "R10");
        prefix(5, 15'h0, "R10");
        cyc(1, 0, 15'h0FC0, 1, 0, 0, 0, "R10");
        cyc(1, 0, 15'h0E38, 1, 0, 0, 0, "R10");
        idle(0, "R10");

        prefix(4, 15'h0, "R11");
        idle(4, "R11"); idle(4, "R11"); idle(4, "R11");
        rd(15'h303F, 5, "R11");
        idle(5, "R11");
        cyc(1, 0, 15'h0C63, 0, 0, 0, 1, "R12");
        idle(0, "R12");

        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule